// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block sits at the result end of a two-input single-precision floating-point operation. For each operand it receives the 32-bit word and a class code from the operand decoder, which says whether the operand is an ordinary number, a quiet NaN or a signaling NaN. When at least one operand is a NaN, the selector produces the NaN that the operation must return. Four propagation policies are available on a select input, so one datapath can serve several architectural conventions. A signaling NaN that is chosen always leaves the block quieted. Whenever either operand is signaling, the block raises an invalid flag.

A default-NaN mode input replaces every propagated NaN with the canonical quiet NaN. The invalid flag still follows the operand classes in that mode. When neither operand is a NaN, the valid output stays low and the arithmetic path owns the result. The block is purely combinational: it has no clock and no state.

Top module: `nan_prop_sel`

## Requirements
- R1: When neither operand is classed as a NaN, `valid_o` is 0, `invalid_o` is 0 and `res_o` carries the default NaN 0x7FC00000. Otherwise `valid_o` is 1.
- R2: With policy code 0, the result is B when A is not signaling and B is signaling. It is also B when A is neither signaling nor quiet. In every other case the result is A.
- R3: With policy code 1, the result is A whenever A is a NaN of either kind, and B otherwise. `use_first_i` has no effect under this policy.
- R4: With policy code 2 and `use_first_i` = 1, the result is A if A is any NaN, else B. With `use_first_i` = 0, the result is B if B is any NaN, else A.
- R5: With policy code 3, a signaling NaN paired with a quiet NaN yields the quiet one. A NaN paired with a non-NaN yields the NaN.
- R6: With policy code 3, two NaNs of the same kind yield the one whose fraction field (bits 22:0, compared unsigned) is larger. When the fractions are equal, A wins only if A is positive (bit 31 = 0) and B is negative. Otherwise B wins.
- R7: A chosen signaling NaN is output with fraction bit 22 set and all other bits unchanged. A chosen quiet NaN is output unchanged.
- R8: `invalid_o` is 1 exactly when at least one operand has class code 2 (signaling), whatever the policy or mode.
- R9: When `dflt_mode_i` = 1 and at least one operand is a NaN, `res_o` is 0x7FC00000.
- R10: Class codes are 2 bits: 0 = ordinary number, 1 = quiet NaN, 2 = signaling NaN. Code 3 is treated exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| policy_i | input | 2 | Propagation policy code (0..3) |
| use_first_i | input | 1 | Direction flag for policy 2 |
| dflt_mode_i | input | 1 | Force the default NaN on every NaN result |
| a_cls_i | input | 2 | Class code of operand A |
| b_cls_i | input | 2 | Class code of operand B |
| a_i | input | 32 | Operand A word |
| b_i | input | 32 | Operand B word |
| res_o | output | 32 | Selected, quieted or default NaN |
| invalid_o | output | 1 | A signaling operand was seen |
| valid_o | output | 1 | At least one operand is a NaN |

## Verification
The bench checks the policy-3 magnitude rule with NaN pairs whose fractions differ only in low bits, and with equal fractions of opposite signs in both orders. A design that compares exponent or sign before the fraction, or that inverts the tie-break, returns the wrong operand in these cases. It drives a signaling NaN that loses to a quiet NaN and a signaling NaN under default-NaN mode. A flag wired to the chosen operand, or gated by the mode, drops `invalid_o` in these cases. Reserved class code 3 and `use_first_i` outside policy 2 are also driven, so that a decoder taking code 3 as a NaN, or a policy mux that leaks the flag, produces a visibly different result word.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

  parameter int WORD_W = 32;
  parameter int FRAC_W = 23;

  typedef enum logic [1:0] {
    CLS_NUM    = 2'd0,
    CLS_QUIET  = 2'd1,
    CLS_SIGNAL = 2'd2,
    CLS_RSVD   = 2'd3
  } nan_cls_e;

  typedef enum logic [1:0] {
    POL_ORDERED   = 2'd0,
    POL_FIRST_ANY = 2'd1,
    POL_SWITCH    = 2'd2,
    POL_MAGNITUDE = 2'd3
  } nan_pol_e;

  typedef struct packed {
    logic any;
    logic quiet;
    logic sig;
  } nan_flags_t;

  // Canonical quiet NaN: positive sign, exponent all ones, top fraction bit.
  function automatic logic [WORD_W-1:0] canon_nan(input int ww, input int fw);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int i = fw - 1; i < ww - 1; i++) v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/nanp_decode.sv
// Turns a class code into NaN flags; the reserved code counts as a number (R10).
module nanp_decode
  import nanp_pkg::*;
(
  input  logic [1:0] cls_i,
  output nan_flags_t flg_o
);

  always_comb begin
    flg_o = '0;
    unique case (cls_i)
      CLS_QUIET:  begin flg_o.any = 1'b1; flg_o.quiet = 1'b1; end
      CLS_SIGNAL: begin flg_o.any = 1'b1; flg_o.sig   = 1'b1; end
      default:    flg_o = '0;
    endcase
  end

endmodule

// File: rtl/nanp_rank.sv
// Magnitude ordering for the magnitude policy (R6).
module nanp_rank #(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              a_wins_o
);

  localparam int SIGN_B = WORD_W - 1;

  logic [FRAC_W-1:0] fa, fb;
  logic              frac_gt, frac_eq, sign_win;

  always_comb begin
    fa       = a_i[FRAC_W-1:0];
    fb       = b_i[FRAC_W-1:0];
    frac_gt  = fa > fb;
    frac_eq  = fa == fb;
    sign_win = !a_i[SIGN_B] && b_i[SIGN_B];
    a_wins_o = frac_gt || (frac_eq && sign_win);
  end

endmodule

// File: rtl/nanp_pick.sv
// Chooses the operand that propagates, per policy (R2..R6).
module nanp_pick
  import nanp_pkg::*;
(
  input  logic [1:0] policy_i,
  input  logic       use_first_i,
  input  nan_flags_t a_f_i,
  input  nan_flags_t b_f_i,
  input  logic       a_wins_i,
  output logic       pick_b_o
);

  always_comb begin
    pick_b_o = 1'b0;
    unique case (nan_pol_e'(policy_i))
      POL_ORDERED:   pick_b_o = !a_f_i.sig && (b_f_i.sig || !a_f_i.quiet);
      POL_FIRST_ANY: pick_b_o = !a_f_i.any;
      POL_SWITCH:    pick_b_o = use_first_i ? !a_f_i.any : b_f_i.any;
      POL_MAGNITUDE: begin
        if (a_f_i.sig) begin
          if (b_f_i.sig) pick_b_o = !a_wins_i;
          else           pick_b_o = b_f_i.quiet;
        end else if (a_f_i.quiet) begin
          if (b_f_i.quiet) pick_b_o = !a_wins_i;
          else             pick_b_o = 1'b0;
        end else begin
          pick_b_o = 1'b1;
        end
      end
      default:       pick_b_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nanp_out.sv
// Quiets the selected operand or substitutes the canonical NaN (R1, R7, R9).
module nanp_out
  import nanp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  nan_flags_t        a_f_i,
  input  nan_flags_t        b_f_i,
  input  logic              pick_b_i,
  input  logic              dflt_mode_i,
  output logic [WORD_W-1:0] res_o
);

  localparam int               QBIT = FRAC_W - 1;
  localparam logic [WORD_W-1:0] DNAN = canon_nan(WORD_W, FRAC_W);

  logic [WORD_W-1:0] chosen;
  logic              chosen_sig, any_nan;

  always_comb begin
    chosen     = pick_b_i ? b_i : a_i;
    chosen_sig = pick_b_i ? b_f_i.sig : a_f_i.sig;
    any_nan    = a_f_i.any || b_f_i.any;
    if (!any_nan || dflt_mode_i) begin
      res_o = DNAN;
    end else begin
      res_o = chosen;
      if (chosen_sig) res_o[QBIT] = 1'b1;
    end
  end

endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
  import nanp_pkg::*;
#(
  parameter int WORD_W = nanp_pkg::WORD_W,
  parameter int FRAC_W = nanp_pkg::FRAC_W
) (
  input  logic [1:0]        policy_i,
  input  logic              use_first_i,
  input  logic              dflt_mode_i,
  input  logic [1:0]        a_cls_i,
  input  logic [1:0]        b_cls_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] res_o,
  output logic              invalid_o,
  output logic              valid_o
);

  localparam int NOPS = 2;

  logic [1:0] cls_v [NOPS];
  nan_flags_t flg_v [NOPS];
  logic       a_wins, pick_b;

  assign cls_v[0] = a_cls_i;
  assign cls_v[1] = b_cls_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_dec
    nanp_decode u_dec (.cls_i(cls_v[g]), .flg_o(flg_v[g]));
  end

  nanp_rank #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_rank (
    .a_i(a_i), .b_i(b_i), .a_wins_o(a_wins)
  );

  nanp_pick u_pick (
    .policy_i(policy_i), .use_first_i(use_first_i),
    .a_f_i(flg_v[0]), .b_f_i(flg_v[1]),
    .a_wins_i(a_wins), .pick_b_o(pick_b)
  );

  nanp_out #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_out (
    .a_i(a_i), .b_i(b_i), .a_f_i(flg_v[0]), .b_f_i(flg_v[1]),
    .pick_b_i(pick_b), .dflt_mode_i(dflt_mode_i), .res_o(res_o)
  );

  // R8: invalid follows the classes alone; R1: valid marks a NaN result.
  assign invalid_o = flg_v[0].sig || flg_v[1].sig;
  assign valid_o   = flg_v[0].any || flg_v[1].any;

endmodule

// File: rtl/nan_prop_sel_chk.sv
module nan_prop_sel_chk
  import nanp_pkg::*;
#(
  parameter int WORD_W = nanp_pkg::WORD_W,
  parameter int FRAC_W = nanp_pkg::FRAC_W
) (
  input logic [1:0]        policy_i,
  input logic              use_first_i,
  input logic              dflt_mode_i,
  input logic [1:0]        a_cls_i,
  input logic [1:0]        b_cls_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] res_o,
  input logic              invalid_o,
  input logic              valid_o
);

  localparam logic [WORD_W-1:0] DNAN  = canon_nan(WORD_W, FRAC_W);
  localparam logic [WORD_W-1:0] QMASK = {{(WORD_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);

  logic a_nan, b_nan, any_sig;

  always_comb begin
    a_nan   = (a_cls_i == 2'd1) || (a_cls_i == 2'd2);
    b_nan   = (b_cls_i == 2'd1) || (b_cls_i == 2'd2);
    any_sig = (a_cls_i == 2'd2) || (b_cls_i == 2'd2);

    p_idle_r1: assert (valid_o || (!invalid_o && res_o == DNAN))
      else $error("p_idle_r1");
    p_valid_r10: assert (valid_o == (a_nan || b_nan))
      else $error("p_valid_r10");
    p_inv_r8: assert (invalid_o == any_sig)
      else $error("p_inv_r8");
    p_dflt_r9: assert (!(valid_o && dflt_mode_i) || res_o == DNAN)
      else $error("p_dflt_r9");
    p_src_r7: assert (!(valid_o && !dflt_mode_i) ||
                      res_o == (a_i | QMASK) || res_o == (b_i | QMASK))
      else $error("p_src_r7");
    p_first_r3: assert (!(policy_i == 2'd1 && a_nan && !dflt_mode_i) ||
                        res_o == (a_i | QMASK))
      else $error("p_first_r3");
    p_switch_r4: assert (!(policy_i == 2'd2 && !use_first_i && b_nan && !dflt_mode_i) ||
                         res_o == (b_i | QMASK))
      else $error("p_switch_r4");
  end

endmodule

bind nan_prop_sel nan_prop_sel_chk #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_chk (
  .policy_i(policy_i), .use_first_i(use_first_i), .dflt_mode_i(dflt_mode_i),
  .a_cls_i(a_cls_i), .b_cls_i(b_cls_i), .a_i(a_i), .b_i(b_i),
  .res_o(res_o), .invalid_o(invalid_o), .valid_o(valid_o)
);

// File: tb/nan_prop_sel_test.sv
module nan_prop_sel_test;

  logic clk;
  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [1:0]  policy, a_cls, b_cls;
  logic        use_first, dflt_mode;
  logic [31:0] a_w, b_w, res;
  logic        invalid, valid;

  nan_prop_sel uut (
    .policy_i(policy), .use_first_i(use_first), .dflt_mode_i(dflt_mode),
    .a_cls_i(a_cls), .b_cls_i(b_cls), .a_i(a_w), .b_i(b_w),
    .res_o(res), .invalid_o(invalid), .valid_o(valid)
  );

  typedef struct packed {
    logic [1:0]  pol;
    logic        uf;
    logic        dm;
    logic [1:0]  ac;
    logic [1:0]  bc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] er;
    logic        ei;
    logic        ev;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  // class codes: 0 number, 1 quiet, 2 signaling, 3 reserved
  localparam vec_t TBL [NV] = '{
    // R2 ordered policy
    '{2'd0,1'b0,1'b0,2'd2,2'd2,32'h7F800005,32'h7F800003,32'h7FC00005,1'b1,1'b1,4'd2},
    '{2'd0,1'b0,1'b0,2'd1,2'd2,32'h7FC00001,32'h7F800003,32'h7FC00003,1'b1,1'b1,4'd2},
    '{2'd0,1'b0,1'b0,2'd1,2'd1,32'h7FC00001,32'hFFC00010,32'h7FC00001,1'b0,1'b1,4'd2},
    '{2'd0,1'b0,1'b0,2'd0,2'd1,32'h3F800000,32'hFFC00010,32'hFFC00010,1'b0,1'b1,4'd2},
    // R3 first-any policy
    '{2'd1,1'b0,1'b0,2'd1,2'd2,32'h7FC00001,32'h7F800003,32'h7FC00001,1'b1,1'b1,4'd3},
    '{2'd1,1'b0,1'b0,2'd0,2'd2,32'h3F800000,32'h7F800003,32'h7FC00003,1'b1,1'b1,4'd3},
    // R4 switchable policy
    '{2'd2,1'b1,1'b0,2'd1,2'd1,32'h7FC00001,32'hFFC00010,32'h7FC00001,1'b0,1'b1,4'd4},
    '{2'd2,1'b0,1'b0,2'd1,2'd1,32'h7FC00001,32'hFFC00010,32'hFFC00010,1'b0,1'b1,4'd4},
    '{2'd2,1'b0,1'b0,2'd2,2'd0,32'h7F800005,32'h3F800000,32'h7FC00005,1'b1,1'b1,4'd4},
    '{2'd2,1'b1,1'b0,2'd0,2'd1,32'h3F800000,32'hFFC00010,32'hFFC00010,1'b0,1'b1,4'd4},
    // R5 magnitude policy, class rules
    '{2'd3,1'b0,1'b0,2'd2,2'd1,32'h7F800005,32'hFFC00010,32'hFFC00010,1'b1,1'b1,4'd5},
    '{2'd3,1'b0,1'b0,2'd1,2'd2,32'h7FC00001,32'h7F800003,32'h7FC00001,1'b1,1'b1,4'd5},
    '{2'd3,1'b0,1'b0,2'd0,2'd2,32'h3F800000,32'h7F800003,32'h7FC00003,1'b1,1'b1,4'd5},
    '{2'd3,1'b0,1'b0,2'd1,2'd0,32'hFFC00007,32'h3F800000,32'hFFC00007,1'b0,1'b1,4'd5},
    // R6 magnitude and sign tie-break
    '{2'd3,1'b0,1'b0,2'd1,2'd1,32'h7FC00001,32'hFFC00010,32'hFFC00010,1'b0,1'b1,4'd6},
    '{2'd3,1'b0,1'b0,2'd2,2'd2,32'h7F800005,32'h7F800003,32'h7FC00005,1'b1,1'b1,4'd6},
    '{2'd3,1'b0,1'b0,2'd1,2'd1,32'hFFC00001,32'h7FC00001,32'h7FC00001,1'b0,1'b1,4'd6},
    '{2'd3,1'b0,1'b0,2'd1,2'd1,32'h7FC00001,32'hFFC00001,32'h7FC00001,1'b0,1'b1,4'd6},
    '{2'd3,1'b0,1'b0,2'd1,2'd1,32'hFFC00002,32'hFFC00002,32'hFFC00002,1'b0,1'b1,4'd6},
    // R7 quieting keeps sign and payload
    '{2'd1,1'b0,1'b0,2'd2,2'd0,32'hFF812345,32'h00000000,32'hFFC12345,1'b1,1'b1,4'd7},
    // R9 default mode; R8 flag still raised
    '{2'd0,1'b0,1'b1,2'd2,2'd1,32'h7F800005,32'hFFC00010,32'h7FC00000,1'b1,1'b1,4'd9},
    '{2'd3,1'b0,1'b1,2'd1,2'd0,32'hFFC00010,32'h3F800000,32'h7FC00000,1'b0,1'b1,4'd9},
    // R1 no NaN; R10 reserved class
    '{2'd0,1'b0,1'b0,2'd0,2'd0,32'h7F800005,32'h7FC00001,32'h7FC00000,1'b0,1'b0,4'd1},
    '{2'd1,1'b0,1'b0,2'd3,2'd1,32'h7FC00001,32'hFFC00010,32'hFFC00010,1'b0,1'b1,4'd10}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check3(input string tag, input logic [31:0] er,
                        input logic ei, input logic ev);
    checks++;
    if (res !== er || invalid !== ei || valid !== ev) begin
      fails++;
      $display("FAIL %s: res=%h inv=%b val=%b expected res=%h inv=%b val=%b",
               tag, res, invalid, valid, er, ei, ev);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic uf, input logic dm,
                       input logic [1:0] ac, input logic [1:0] bc,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    policy = p; use_first = uf; dflt_mode = dm;
    a_cls = ac; b_cls = bc; a_w = a; b_w = b;
    #5;
  endtask

  initial begin
    policy = '0; use_first = 0; dflt_mode = 0;
    a_cls = '0; b_cls = '0; a_w = '0; b_w = '0;
    #5;
    check3("R1 power-on idle", 32'h7FC00000, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].pol, TBL[i].uf, TBL[i].dm, TBL[i].ac, TBL[i].bc,
            TBL[i].a, TBL[i].b);
      check3($sformatf("R%0d vector %0d", TBL[i].req, i),
             TBL[i].er, TBL[i].ei, TBL[i].ev);
    end

    // R3: use_first has no effect under policy 1
    drive(2'd1, 1'b0, 1'b0, 2'd1, 2'd1, 32'h7FC00001, 32'hFFC00010);
    check3("R3 use_first low", 32'h7FC00001, 1'b0, 1'b1);
    drive(2'd1, 1'b1, 1'b0, 2'd1, 2'd1, 32'h7FC00001, 32'hFFC00010);
    check3("R3 use_first high", 32'h7FC00001, 1'b0, 1'b1);
    // R10: reserved code on both operands is not a NaN
    drive(2'd3, 1'b0, 1'b0, 2'd3, 2'd3, 32'h7F800005, 32'h7FC00001);
    check3("R10 both reserved", 32'h7FC00000, 1'b0, 1'b0);
    // R8: signaling loser still raises invalid under every policy
    for (int p = 0; p < 4; p++) begin
      drive(p[1:0], 1'b0, 1'b0, 2'd1, 2'd2, 32'hFFC00010, 32'h7F800003);
      checks++;
      if (invalid !== 1'b1) begin
        fails++;
        $display("FAIL R8 policy %0d: inv=%b expected 1", p, invalid);
      end
    end
    // R7: a quiet NaN passes bit-exact
    drive(2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 32'hFFFFFFFF, 32'h00000000);
    check3("R7 quiet unchanged", 32'hFFFFFFFF, 1'b0, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule